// File: doc/BRIEF.md
# J1850 Transmit Opcode Queue Controller

This block sits between a host that issues transmit opcodes and the symbol transmitter of a J1850 bus node. The host may post an opcode before the bus is ready for it. The block holds the opcode until the frame on the bus reaches the point where the transmission may legally start. It then hands the opcode to the transmitter as a single-cycle start request.

Two classes of opcode are kept, each in its own slot. A message opcode, with or without CRC, belongs to the next frame. It is released once the bus has gone idle after a nominal inter-frame separation. It is also released when another node starts a frame early, after minimum end of frame. An in-frame response opcode belongs to the current frame and is released at end of data. The block follows the frame phase from decoded receive-symbol pulses and clears a slot when one of the errors that apply to its class occurs. A ready flag tells the transmitter that a queued message has reached its release window. A sticky flag records that a host write overwrote an opcode still waiting in its slot.

Top module: `j1850_txq_ctrl`

## Requirements
- R1: After reset, tx_start, tx_ready and ovr_flag are 0, both slots are empty and the frame phase is idle.
- R2: An opcode whose most significant bit is 1 is an in-frame response; any other opcode is a message. A response write is ignored while the phase is idle, meaning no start-of-frame has been seen since reset or since the last nominal inter-frame separation.
- R3: A queued message is released when the phase is idle, or in the cycle a start-of-frame pulse arrives after minimum end of frame. It is never released between a start-of-frame and the following minimum end of frame.
- R4: tx_ready is 1 exactly when a message is queued and the phase is past minimum end of frame or idle. It is 0 while the current frame is still in progress.
- R5: A queued response is released in the cycle of a nominal or minimum end-of-data pulse.
- R6: When both slots are eligible in the same cycle, the response is released and the message stays queued.
- R7: A release drives tx_start high for exactly one clock, in the cycle after the eligible cycle, with tx_op equal to the released opcode. The slot is emptied at the same time.
- R8: A queued message is discarded by a receive-break error. Lost-arbitration, invalid-bit, invalid-frame and CRC errors leave it queued.
- R9: A queued response is discarded by invalid-bit, invalid-frame, CRC or receive-break errors. It is also discarded by a length-check error when len_chk_en is 1, and by a frame-limit error when flim_chk_en is 1. Lost-arbitration leaves it queued.
- R10: A write to an occupied slot that is not being released replaces the opcode and sets ovr_flag, which stays 1 until reset.
- R11: A discard wins over a release in the same cycle. A write in the same cycle as a discard of its slot leaves the new opcode queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sym_sof | input | 1 | Pulse: start of a start-of-frame symbol seen on the receive line |
| sym_eod_nom | input | 1 | Pulse: nominal end-of-data symbol seen |
| sym_eod_min | input | 1 | Pulse: minimum end of data reached |
| sym_eof_min | input | 1 | Pulse: minimum end of frame reached |
| sym_ifs_nom | input | 1 | Pulse: nominal inter-frame separation seen |
| err_tla | input | 1 | Pulse: transmitter lost arbitration |
| err_ibd | input | 1 | Pulse: invalid bit detected |
| err_ifd | input | 1 | Pulse: invalid frame detected |
| err_crc | input | 1 | Pulse: CRC error |
| err_brk | input | 1 | Pulse: break received |
| err_len | input | 1 | Pulse: message length check failed |
| err_flim | input | 1 | Pulse: frame length limit exceeded |
| len_chk_en | input | 1 | Enables err_len to discard a response |
| flim_chk_en | input | 1 | Enables err_flim to discard a response |
| op_wr | input | 1 | Host opcode write strobe |
| op_data | input | OP_W | Opcode written by the host |
| tx_start | output | 1 | One-clock start request to the transmitter |
| tx_op | output | OP_W | Opcode being started |
| tx_ready | output | 1 | Queued message has reached its release window |
| ovr_flag | output | 1 | Sticky overwrite indication |

## Verification
The hardest case to reach is both slots becoming eligible in the same cycle. In a well-formed frame the message window and the end-of-data point never coincide. The bench gets there by writing a response after end of data, so it waits for the next end of data. It then carries the frame past minimum end of frame with a message also queued, and drives an early start-of-frame together with a minimum end-of-data pulse. The priority and the survival of the message are then checked through tx_op and through the later release at the next separation. The discard-versus-release and write-versus-discard collisions are reached the same way, by putting the competing pulses on one clock.

// File: rtl/txq_pkg.sv
// Package: shared types and class indices for the transmit opcode queue.
// Assumes: exactly two queue classes; the index order sets the array layout.
package txq_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,   // bus idle after a nominal separation
        PH_DATA = 2'd1,   // start-of-frame seen, frame body running
        PH_RESP = 2'd2,   // end of data seen, response window
        PH_EOF  = 2'd3    // minimum end of frame reached
    } phase_t;

    localparam int NUM_CLASS = 2;
    localparam int CL_MSG    = 0;
    localparam int CL_IFR    = 1;
endpackage

// File: rtl/txq_phase.sv
// Module: frame phase tracker.
// Follows the frame on the receive line from decoded symbol pulses.
// Assumes: the pulses are one clock wide; start-of-frame has the highest
// priority, then separation, then end of frame, then end of data.
module txq_phase
    import txq_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   sof,
    input  logic   eod_any,
    input  logic   eof_min,
    input  logic   ifs_nom,
    output phase_t phase
);
    // Purpose: step the phase on each symbol pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)       phase <= PH_IDLE;
        else if (sof)     phase <= PH_DATA;
        else if (ifs_nom) phase <= PH_IDLE;
        else if (eof_min) phase <= PH_EOF;
        else if (eod_any) phase <= PH_RESP;
    end

    // R3: a start-of-frame always opens a new frame body
    a_r3_sof_opens_frame: assert property (@(posedge clk) disable iff (!rst_n)
        sof |=> phase == PH_DATA);
endmodule

// File: rtl/txq_slot.sv
// Module: one single-entry opcode slot.
// Holds one opcode. A load overwrites the slot; cancel or release empties it.
// Assumes: load has priority over cancel and release in the same cycle.
module txq_slot #(
    parameter int OP_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [OP_W-1:0] load_op,
    input  logic            cancel,
    input  logic            rel,
    output logic            vld,
    output logic [OP_W-1:0] op,
    output logic            ovr_hit
);
    // Purpose: an overwrite is a load onto a held opcode that is not leaving.
    assign ovr_hit = load && vld && !rel;

    // Purpose: keep the slot contents.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld <= 1'b0;
            op  <= '0;
        end else if (load) begin
            vld <= 1'b1;
            op  <= load_op;
        end else if (cancel || rel) begin
            vld <= 1'b0;
        end
    end

    // R11: a load is never lost to a same-cycle cancel
    a_r11_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> vld && op == $past(load_op));
    // R7: a release without a load empties the slot
    a_r7_rel_clears: assert property (@(posedge clk) disable iff (!rst_n)
        rel && !load |=> !vld);
endmodule

// File: rtl/txq_release.sv
// Module: release arbiter.
// Decides which slot may start this cycle. A response is eligible on
// end of data. A message is eligible while idle, or on an early start-of-frame
// after minimum end of frame. A cancelled slot is never eligible. The
// response wins a tie.
// Assumes: purely combinational; the outputs are registered by the parent.
module txq_release
    import txq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_CLASS-1:0] vld,
    input  logic [NUM_CLASS-1:0] cancel,
    input  phase_t               phase,
    input  logic                 sof,
    input  logic                 eod_any,
    output logic [NUM_CLASS-1:0] rel
);
    logic elig_msg;
    logic elig_ifr;

    // Purpose: eligibility of each class and the fixed priority between them.
    always_comb begin
        elig_ifr    = vld[CL_IFR] && !cancel[CL_IFR] && eod_any;
        elig_msg    = vld[CL_MSG] && !cancel[CL_MSG] &&
                      (phase == PH_IDLE || (phase == PH_EOF && sof));
        rel         = '0;
        rel[CL_IFR] = elig_ifr;
        rel[CL_MSG] = elig_msg && !elig_ifr;
    end

    // R6: at most one release per cycle
    a_r6_single_release: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rel));
    // R11: a cancelled slot is not released
    a_r11_cancel_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (rel & cancel) == '0);
endmodule

// File: rtl/j1850_txq_ctrl.sv
// Module: J1850 transmit opcode queue controller (top).
// Queues host opcodes in one slot per class and releases each at its legal
// point in the frame. It cancels them by error class and flags overwrites.
// Assumes: all symbol and error inputs are one-clock pulses, synchronous to clk.
module j1850_txq_ctrl
    import txq_pkg::*;
#(
    parameter int OP_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sym_sof,
    input  logic            sym_eod_nom,
    input  logic            sym_eod_min,
    input  logic            sym_eof_min,
    input  logic            sym_ifs_nom,
    input  logic            err_tla,
    input  logic            err_ibd,
    input  logic            err_ifd,
    input  logic            err_crc,
    input  logic            err_brk,
    input  logic            err_len,
    input  logic            err_flim,
    input  logic            len_chk_en,
    input  logic            flim_chk_en,
    input  logic            op_wr,
    input  logic [OP_W-1:0] op_data,
    output logic            tx_start,
    output logic [OP_W-1:0] tx_op,
    output logic            tx_ready,
    output logic            ovr_flag
);
    localparam int CLS_BIT = OP_W - 1;

    phase_t                 phase_q;
    logic                   eod_any;
    logic                   op_is_ifr;
    logic [NUM_CLASS-1:0]   slot_load;
    logic [NUM_CLASS-1:0]   slot_cancel;
    logic [NUM_CLASS-1:0]   slot_rel;
    logic [NUM_CLASS-1:0]   slot_vld;
    logic [NUM_CLASS-1:0]   slot_ovr;
    logic [OP_W-1:0]        slot_op [NUM_CLASS];

    assign eod_any   = sym_eod_nom || sym_eod_min;
    assign op_is_ifr = op_data[CLS_BIT];

    txq_phase u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .sof     (sym_sof),
        .eod_any (eod_any),
        .eof_min (sym_eof_min),
        .ifs_nom (sym_ifs_nom),
        .phase   (phase_q)
    );

    // Purpose: route writes to their class; a response needs a frame begun.
    always_comb begin
        slot_load         = '0;
        slot_load[CL_MSG] = op_wr && !op_is_ifr;
        slot_load[CL_IFR] = op_wr && op_is_ifr && (phase_q != PH_IDLE);
    end

    // Purpose: per-class cancellation sets.
    always_comb begin
        slot_cancel         = '0;
        slot_cancel[CL_MSG] = err_brk;
        slot_cancel[CL_IFR] = err_ibd || err_ifd || err_crc || err_brk ||
                              (err_len && len_chk_en) ||
                              (err_flim && flim_chk_en);
    end

    for (genvar g = 0; g < NUM_CLASS; g++) begin : g_slot
        txq_slot #(.OP_W(OP_W)) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .load    (slot_load[g]),
            .load_op (op_data),
            .cancel  (slot_cancel[g]),
            .rel     (slot_rel[g]),
            .vld     (slot_vld[g]),
            .op      (slot_op[g]),
            .ovr_hit (slot_ovr[g])
        );
    end

    txq_release u_rel (
        .clk     (clk),
        .rst_n   (rst_n),
        .vld     (slot_vld),
        .cancel  (slot_cancel),
        .phase   (phase_q),
        .sof     (sym_sof),
        .eod_any (eod_any),
        .rel     (slot_rel)
    );

    // Purpose: register the start pulse and the opcode being started.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_start <= 1'b0;
            tx_op    <= '0;
        end else begin
            tx_start <= |slot_rel;
            if (slot_rel[CL_IFR])      tx_op <= slot_op[CL_IFR];
            else if (slot_rel[CL_MSG]) tx_op <= slot_op[CL_MSG];
        end
    end

    // Purpose: sticky overwrite flag.
    always_ff @(posedge clk) begin
        if (!rst_n) ovr_flag <= 1'b0;
        else        ovr_flag <= ovr_flag || (|slot_ovr);
    end

    // Purpose: message has reached its release window.
    assign tx_ready = slot_vld[CL_MSG] &&
                      (phase_q == PH_EOF || phase_q == PH_IDLE);

    // R3: a started message was eligible by phase in the previous cycle
    a_r3_msg_window: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start && !tx_op[CLS_BIT] |->
            $past(phase_q == PH_IDLE || (phase_q == PH_EOF && sym_sof)));
    // R5: a started response follows an end-of-data pulse
    a_r5_ifr_on_eod: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start && tx_op[CLS_BIT] |-> $past(sym_eod_nom || sym_eod_min));
    // R8: a break empties both slots unless a write refills one
    a_r8_brk_clears: assert property (@(posedge clk) disable iff (!rst_n)
        err_brk && !op_wr |=> slot_vld == '0);
    // R8: lost arbitration alone does not remove a queued message
    a_r8_tla_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        err_tla && !err_brk && slot_vld[CL_MSG] && !slot_rel[CL_MSG] |=>
            slot_vld[CL_MSG]);
    // R10: the overwrite flag is sticky and only a write can raise it
    a_r10_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_flag |=> ovr_flag);
    a_r10_ovr_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_flag) |-> $past(op_wr));
    // R4: ready never shows during a frame body
    a_r4_ready_window: assert property (@(posedge clk) disable iff (!rst_n)
        sym_sof |=> !tx_ready);
endmodule

// File: tb/tb_j1850_txq_ctrl.sv
module tb_j1850_txq_ctrl;
    localparam int OP_W = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sym_sof = 0, sym_eod_nom = 0, sym_eod_min = 0, sym_eof_min = 0, sym_ifs_nom = 0;
    logic err_tla = 0, err_ibd = 0, err_ifd = 0, err_crc = 0, err_brk = 0;
    logic err_len = 0, err_flim = 0, len_chk_en = 0, flim_chk_en = 0;
    logic op_wr = 0;
    logic [OP_W-1:0] op_data = '0;
    logic tx_start, tx_ready, ovr_flag;
    logic [OP_W-1:0] tx_op;

    int n_checks = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    j1850_txq_ctrl #(.OP_W(OP_W)) dut (
        .clk(clk), .rst_n(rst_n),
        .sym_sof(sym_sof), .sym_eod_nom(sym_eod_nom), .sym_eod_min(sym_eod_min),
        .sym_eof_min(sym_eof_min), .sym_ifs_nom(sym_ifs_nom),
        .err_tla(err_tla), .err_ibd(err_ibd), .err_ifd(err_ifd), .err_crc(err_crc),
        .err_brk(err_brk), .err_len(err_len), .err_flim(err_flim),
        .len_chk_en(len_chk_en), .flim_chk_en(flim_chk_en),
        .op_wr(op_wr), .op_data(op_data),
        .tx_start(tx_start), .tx_op(tx_op), .tx_ready(tx_ready), .ovr_flag(ovr_flag)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick(); @(negedge clk); endtask
    task automatic p_sof();  sym_sof = 1;     tick(); sym_sof = 0;     endtask
    task automatic p_eodn(); sym_eod_nom = 1; tick(); sym_eod_nom = 0; endtask
    task automatic p_eodm(); sym_eod_min = 1; tick(); sym_eod_min = 0; endtask
    task automatic p_eof();  sym_eof_min = 1; tick(); sym_eof_min = 0; endtask
    task automatic p_ifs();  sym_ifs_nom = 1; tick(); sym_ifs_nom = 0; endtask
    task automatic wr(input logic [OP_W-1:0] v);
        op_wr = 1; op_data = v; tick(); op_wr = 0;
    endtask
    task automatic set_err(input int k, input logic v);
        case (k)
            0: err_tla = v;  1: err_ibd = v;  2: err_ifd = v;  3: err_crc = v;
            4: err_brk = v;  5: err_len = v;  default: err_flim = v;
        endcase
    endtask
    task automatic p_err(input int k);
        set_err(k, 1); tick(); set_err(k, 0);
    endtask

    task automatic t_reset();
        chk("R1 tx_start", tx_start, 0);
        chk("R1 tx_ready", tx_ready, 0);
        chk("R1 ovr_flag", ovr_flag, 0);
    endtask

    task automatic t_msg_idle();
        wr(4'h3);
        chk("R4 ready when idle", tx_ready, 1);
        chk("R7 no start yet", tx_start, 0);
        tick();
        chk("R3 idle release", tx_start, 1);
        chk("R7 op", tx_op, 3);
        tick();
        chk("R7 one clock", tx_start, 0);
        chk("R7 slot cleared", tx_ready, 0);
    endtask

    task automatic t_msg_frame();
        p_sof(); wr(4'h5); tick(); tick();
        chk("R3 held in frame", tx_start, 0);
        chk("R4 not ready in frame", tx_ready, 0);
        p_eodn();
        chk("R4 not ready at eod", tx_ready, 0);
        chk("R3 held at eod", tx_start, 0);
        p_eof();
        chk("R4 ready at eof", tx_ready, 1);
        chk("R3 held at eof", tx_start, 0);
        p_ifs(); tick();
        chk("R3 release after ifs", tx_start, 1);
        chk("R3 op", tx_op, 5);
        tick();
    endtask

    task automatic t_msg_early();
        p_sof(); wr(4'h6); p_eodm(); p_eof();
        p_sof();
        chk("R3 early sof release", tx_start, 1);
        chk("R3 early op", tx_op, 6);
        p_eodn(); p_eof(); p_ifs(); tick();
        chk("R7 no repeat", tx_start, 0);
    endtask

    task automatic t_msg_errs();
        p_sof(); wr(4'h7);
        for (int k = 0; k < 4; k++) p_err(k);
        p_eodn(); p_eof();
        chk("R8 survives tla/ibd/ifd/crc", tx_ready, 1);
        p_ifs(); tick();
        chk("R8 released after errors", tx_start, 1);
        chk("R8 op", tx_op, 7);
        p_sof(); wr(4'h2); p_err(4); p_eodn(); p_eof();
        chk("R8 brk cancels ready", tx_ready, 0);
        p_ifs(); tick();
        chk("R8 brk no start", tx_start, 0);
        tick();
        chk("R8 brk no start later", tx_start, 0);
    endtask

    task automatic t_ifr_basic();
        wr(4'h9);
        p_sof(); p_eodm();
        chk("R2 idle ifr ignored", tx_start, 0);
        p_eof(); p_ifs();
        p_sof(); wr(4'hA); tick();
        chk("R5 held before eod", tx_start, 0);
        p_eodm();
        chk("R5 eod_min release", tx_start, 1);
        chk("R5 op", tx_op, 10);
        p_eof(); p_ifs();
        p_sof(); wr(4'hB); p_eodn();
        chk("R5 eod_nom release", tx_start, 1);
        chk("R5 op nom", tx_op, 11);
        p_eof(); p_ifs();
    endtask

    task automatic ifr_err(input int k, input int exp_start, input string tag);
        p_sof(); wr(4'hD); p_err(k); p_eodn();
        chk(tag, tx_start, exp_start);
        if (exp_start == 1) chk({tag, " op"}, tx_op, 13);
        p_eof(); p_ifs();
    endtask

    task automatic t_ifr_cancel();
        ifr_err(0, 1, "R9 tla keeps ifr");
        ifr_err(1, 0, "R9 ibd cancels");
        ifr_err(2, 0, "R9 ifd cancels");
        ifr_err(3, 0, "R9 crc cancels");
        ifr_err(4, 0, "R9 brk cancels");
        len_chk_en = 0; ifr_err(5, 1, "R9 len disabled keeps");
        len_chk_en = 1; ifr_err(5, 0, "R9 len enabled cancels");
        flim_chk_en = 0; ifr_err(6, 1, "R9 flim disabled keeps");
        flim_chk_en = 1; ifr_err(6, 0, "R9 flim enabled cancels");
        len_chk_en = 0; flim_chk_en = 0;
    endtask

    task automatic t_priority();
        p_sof(); wr(4'h2); p_eodn(); wr(4'hE); p_eof();
        chk("R6 msg ready before tie", tx_ready, 1);
        sym_sof = 1; sym_eod_min = 1; tick(); sym_sof = 0; sym_eod_min = 0;
        chk("R6 tie start", tx_start, 1);
        chk("R6 ifr wins", tx_op, 14);
        tick();
        chk("R6 msg not started", tx_start, 0);
        p_eodn(); p_eof(); p_ifs(); tick();
        chk("R6 msg kept", tx_start, 1);
        chk("R6 msg op", tx_op, 2);
        tick();
    endtask

    task automatic t_overrun();
        p_sof(); wr(4'h1);
        chk("R10 no ovr single", ovr_flag, 0);
        wr(4'h4);
        chk("R10 ovr set", ovr_flag, 1);
        p_eodn(); p_eof(); p_ifs(); tick();
        chk("R10 overwritten op", tx_op, 4);
        chk("R10 start", tx_start, 1);
        tick();
        chk("R10 sticky", ovr_flag, 1);
    endtask

    task automatic t_collide();
        p_sof(); wr(4'hE);
        sym_eod_nom = 1; err_ibd = 1; tick(); sym_eod_nom = 0; err_ibd = 0;
        chk("R11 cancel beats release", tx_start, 0);
        wr(4'hF);
        op_wr = 1; op_data = 4'hC; err_ibd = 1; tick(); op_wr = 0; err_ibd = 0;
        p_eodn();
        chk("R11 write beats cancel", tx_start, 1);
        chk("R11 new op", tx_op, 12);
        p_eof(); p_ifs();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        tick();
        t_reset();
        t_msg_idle();
        t_msg_frame();
        t_msg_early();
        t_msg_errs();
        t_ifr_basic();
        t_ifr_cancel();
        t_priority();
        t_overrun();
        t_collide();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule